// File: doc/BRIEF.md
# Chained Hash Table Probe Engine

This block runs the probe side of an in-memory hash join. Each incoming probe tuple (join key plus a payload) becomes an independent thread. The thread hashes its key to a bucket index, reads that bucket's head pointer from external memory, and then walks the bucket's linked list, reading one node per pass through the datapath. Every node whose key equals the probe key yields one joined record carrying the key, the probe payload and the build payload.

Memory latency is hidden by keeping up to `NT` threads in flight. Every read carries the thread's tag, and responses may return in any order. A thread whose chain continues is placed in a recirculation queue and re-enters the datapath to fetch its next node. Recirculated threads always win over new tuples at the datapath entry, so new input stalls while the queue holds work. The hash function and the node layout are shared with whatever engine built the table.

Top module: `hash_probe_engine`

## Requirements
- R1: The bucket index of a key is bits [KW-1:KW-BW] of the low KW bits of key*HASH_MUL, and the head read for a tuple goes to memory address equal to that index. Head reads are issued in the order tuples are accepted.
- R2: A memory response word is {key[KW], payload[PW], next[AW]} with the key in the top bits. For a head read only the next field is used, as the head pointer. A pointer value of zero means an empty bucket or the end of a chain.
- R3: A tuple whose bucket head pointer is zero retires without producing any result and without any node read.
- R4: Each node read whose node key equals the thread's probe key produces exactly one result {key, probe payload, build payload}. Non-matching nodes produce none.
- R5: A thread with a non-zero pointer issues a node read at that pointer address. It keeps following next pointers until a node with next equal to zero has been processed, and then it retires.
- R6: A thread waiting in the recirculation queue has strict priority. In the cycle after a response with a non-zero pointer is delivered, in_ready is low.
- R7: At most NT threads are outstanding. in_ready is low while all tags are in use, and out-of-order responses are matched to threads by tag.
- R8: done is high only when in_eos is high, no new tuple is offered, no thread is in flight and the recirculation queue is empty. It is low while any thread is outstanding.
- R9: After reset, in_ready is high, and mem_req_valid, res_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Probe tuple offered |
| in_ready | output | 1 | Tuple accepted on this edge when valid |
| in_key | input | KW | Probe join key |
| in_pay | input | PW | Probe payload |
| in_eos | input | 1 | No further tuples will be offered |
| mem_req_valid | output | 1 | Read request (always accepted) |
| mem_req_addr | output | AW | Bucket index or node pointer |
| mem_req_tag | output | TW | Thread tag of the request |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_tag | input | TW | Tag of the response |
| mem_rsp_data | input | KW+PW+AW | {key, payload, next} |
| res_valid | output | 1 | Joined record valid |
| res_key | output | KW | Matched key |
| res_probe_pay | output | PW | Probe-side payload |
| res_build_pay | output | PW | Build-side payload |
| done | output | 1 | Probe finished |

## Verification
The engine is first probed against an empty table, which shows that tuples are dropped and that head addresses follow the hash. Next comes a table of unique keys probed by a key sweep that half hits and half misses, which tells single-node matches apart from misses in occupied buckets. A skewed table with long chains of repeated keys follows, probed by repeated and absent keys, which exercises multi-node walks, multiple matches per thread and recirculation priority. Finally, a run in which memory withholds all responses fills every tag, which shows the capacity stall and that done stays low while threads are outstanding. The memory model answers in a pseudo-random order, so the tag matching is tested in every run.

// File: rtl/hpe_pkg.sv
package hpe_pkg;
  typedef enum logic {
    VISIT_NODE = 1'b0,
    VISIT_HEAD = 1'b1
  } visit_e;
endpackage

// File: rtl/hpe_hash.sv
module hpe_hash #(
  parameter int KW = 16,
  parameter int BW = 4,
  parameter int unsigned HASH_MUL = 'h9E37
) (
  input  logic [KW-1:0] key,
  output logic [BW-1:0] idx
);
  logic [KW-1:0] prod;

  always_comb begin
    prod = key * KW'(HASH_MUL);
    idx  = prod[KW-1 -: BW];
  end
endmodule

// File: rtl/hpe_thread_table.sv
module hpe_thread_table
  import hpe_pkg::*;
#(
  parameter int NT = 4,
  parameter int KW = 16,
  parameter int PW = 16,
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic [KW-1:0] alloc_key,
  input  logic [PW-1:0] alloc_pay,
  output logic [TW-1:0] alloc_tag,
  output logic          free_avail,
  input  logic [TW-1:0] look_tag,
  output logic [KW-1:0] look_key,
  output logic [PW-1:0] look_pay,
  output visit_e        look_visit,
  input  logic          seen_en,
  input  logic          ret_en,
  output logic          any_busy
);
  logic [NT-1:0] busy_q, busy_d;
  logic [NT-1:0] head_q, head_d;
  logic [KW-1:0] key_q [NT];
  logic [PW-1:0] pay_q [NT];

  // lowest free tag
  always_comb begin
    alloc_tag  = '0;
    free_avail = 1'b0;
    for (int i = NT - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        alloc_tag  = TW'(i);
        free_avail = 1'b1;
      end
    end
  end

  always_comb begin
    busy_d = busy_q;
    head_d = head_q;
    if (seen_en) head_d[look_tag] = 1'b0;
    if (ret_en)  busy_d[look_tag] = 1'b0;
    if (alloc_en) begin
      busy_d[alloc_tag] = 1'b1;
      head_d[alloc_tag] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      head_q <= '0;
    end else begin
      busy_q <= busy_d;
      head_q <= head_d;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      key_q[alloc_tag] <= alloc_key;
      pay_q[alloc_tag] <= alloc_pay;
    end
  end

  assign look_key   = key_q[look_tag];
  assign look_pay   = pay_q[look_tag];
  assign look_visit = head_q[look_tag] ? VISIT_HEAD : VISIT_NODE;
  assign any_busy   = |busy_q;

  // R7: a response only retires a thread that owns its tag
  p_ret_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_en |-> busy_q[look_tag]);
  // R7: a newly allocated tag is never the one being retired
  p_alloc_distinct_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && ret_en) |-> (alloc_tag != look_tag));
endmodule

// File: rtl/hpe_recycle_fifo.sv
module hpe_recycle_fifo #(
  parameter int DEPTH = 4,
  parameter int TW    = 2,
  parameter int AW    = 8,
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [TW-1:0] push_tag,
  input  logic [AW-1:0] push_ptr,
  input  logic          pop,
  output logic          empty,
  output logic [TW-1:0] head_tag,
  output logic [AW-1:0] head_ptr
);
  logic [TW-1:0]   tag_q [DEPTH];
  logic [AW-1:0]   ptr_q [DEPTH];
  logic [PTRW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == PTRW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == PTRW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      tag_q[wr_q] <= push_tag;
      ptr_q[wr_q] <= push_ptr;
    end
  end

  assign empty    = (cnt_q == '0);
  assign head_tag = tag_q[rd_q];
  assign head_ptr = ptr_q[rd_q];

  // R6: the queue holds one slot per thread, so it never overflows
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (cnt_q != CW'(DEPTH)));
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/hash_probe_engine.sv
module hash_probe_engine
  import hpe_pkg::*;
#(
  parameter int KW = 16,
  parameter int PW = 16,
  parameter int AW = 8,
  parameter int BW = 4,
  parameter int NT = 4,
  parameter int unsigned HASH_MUL = 'h9E37,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1,
  localparam int DW = KW + PW + AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [KW-1:0] in_key,
  input  logic [PW-1:0] in_pay,
  input  logic          in_eos,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  output logic [TW-1:0] mem_req_tag,
  input  logic          mem_rsp_valid,
  input  logic [TW-1:0] mem_rsp_tag,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          res_valid,
  output logic [KW-1:0] res_key,
  output logic [PW-1:0] res_probe_pay,
  output logic [PW-1:0] res_build_pay,
  output logic          done
);
  logic [BW-1:0] bkt_idx;
  logic [TW-1:0] alloc_tag, rq_tag;
  logic [AW-1:0] rq_ptr;
  logic          free_avail, any_busy, rq_empty;
  logic [KW-1:0] ctx_key;
  logic [PW-1:0] ctx_pay;
  visit_e        ctx_visit;

  logic [KW-1:0] rsp_key;
  logic [PW-1:0] rsp_pay;
  logic [AW-1:0] rsp_next;
  logic          take_new, take_old, chain_more, chain_end, hit;

  logic          req_v_q, req_v_d;
  logic [AW-1:0] req_a_q, req_a_d;
  logic [TW-1:0] req_t_q, req_t_d;
  logic          res_v_q, res_v_d, done_q, done_d;
  logic [KW-1:0] res_k_q;
  logic [PW-1:0] res_pp_q, res_bp_q;

  hpe_hash #(.KW(KW), .BW(BW), .HASH_MUL(HASH_MUL)) u_hash (
    .key (in_key),
    .idx (bkt_idx)
  );

  assign {rsp_key, rsp_pay, rsp_next} = mem_rsp_data;

  // entry arbiter: recirculated threads first
  always_comb begin
    take_old = !rq_empty;
    in_ready = rq_empty && free_avail;
    take_new = in_valid && in_ready;
  end

  // response classification
  always_comb begin
    chain_more = mem_rsp_valid && (rsp_next != '0);
    chain_end  = mem_rsp_valid && (rsp_next == '0);
    hit        = mem_rsp_valid && (ctx_visit == VISIT_NODE) && (rsp_key == ctx_key);
  end

  hpe_thread_table #(.NT(NT), .KW(KW), .PW(PW), .TW(TW)) u_threads (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (take_new),
    .alloc_key  (in_key),
    .alloc_pay  (in_pay),
    .alloc_tag  (alloc_tag),
    .free_avail (free_avail),
    .look_tag   (mem_rsp_tag),
    .look_key   (ctx_key),
    .look_pay   (ctx_pay),
    .look_visit (ctx_visit),
    .seen_en    (mem_rsp_valid),
    .ret_en     (chain_end),
    .any_busy   (any_busy)
  );

  hpe_recycle_fifo #(.DEPTH(NT), .TW(TW), .AW(AW)) u_recycle (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (chain_more),
    .push_tag (mem_rsp_tag),
    .push_ptr (rsp_next),
    .pop      (take_old),
    .empty    (rq_empty),
    .head_tag (rq_tag),
    .head_ptr (rq_ptr)
  );

  // next-state
  always_comb begin
    req_v_d = take_old || take_new;
    req_a_d = take_old ? rq_ptr : {{(AW-BW){1'b0}}, bkt_idx};
    req_t_d = take_old ? rq_tag : alloc_tag;
    res_v_d = hit;
    done_d  = in_eos && !in_valid && !any_busy && rq_empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_v_q <= 1'b0;
      res_v_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      req_v_q <= req_v_d;
      res_v_q <= res_v_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (req_v_d) begin
      req_a_q <= req_a_d;
      req_t_q <= req_t_d;
    end
    if (hit) begin
      res_k_q  <= ctx_key;
      res_pp_q <= ctx_pay;
      res_bp_q <= rsp_pay;
    end
  end

  assign mem_req_valid = req_v_q;
  assign mem_req_addr  = req_a_q;
  assign mem_req_tag   = req_t_q;
  assign res_valid     = res_v_q;
  assign res_key       = res_k_q;
  assign res_probe_pay = res_pp_q;
  assign res_build_pay = res_bp_q;
  assign done          = done_q;

  // R6: a continuing chain blocks new input on the following cycle
  p_recycle_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && (rsp_next != '0)) |=> !in_ready);
  // R4: a result always follows a memory response
  p_result_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(mem_rsp_valid));
  // R3: an empty bucket yields no result
  p_empty_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && (ctx_visit == VISIT_HEAD)) |=> !res_valid);
  // R8: done implies end of stream was signalled and no request is issued
  p_done_eos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(in_eos) && !mem_req_valid));
endmodule

// File: tb/hash_probe_engine_test.sv
`timescale 1ns/1ps
module hash_probe_engine_test;
  localparam int KW = 16, PW = 16, AW = 8, BW = 4, NT = 4, TW = 2;
  localparam int DW = KW + PW + AW;
  localparam int NB = 1 << BW;
  localparam int MEMN = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_eos = 1'b0;
  logic [KW-1:0] in_key = '0;
  logic [PW-1:0] in_pay = '0;
  logic in_ready, mem_req_valid, res_valid, done;
  logic [AW-1:0] mem_req_addr;
  logic [TW-1:0] mem_req_tag;
  logic mem_rsp_valid = 1'b0;
  logic [TW-1:0] mem_rsp_tag = '0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic [KW-1:0] res_key;
  logic [PW-1:0] res_probe_pay, res_build_pay;

  always #5 clk = ~clk;

  hash_probe_engine uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .in_pay(in_pay), .in_eos(in_eos),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_key(res_key), .res_probe_pay(res_probe_pay),
    .res_build_pay(res_build_pay), .done(done)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory image
  logic [KW-1:0] mk [MEMN];
  logic [PW-1:0] mp [MEMN];
  logic [AW-1:0] mn [MEMN];
  int node_top;

  function automatic logic [BW-1:0] bh(input logic [KW-1:0] k);
    longint p;
    p = (longint'(k) * 'h9E37) % 65536;
    return BW'(p / (65536 / NB));
  endfunction

  task automatic clear_table();
    for (int a = 0; a < MEMN; a++) begin mk[a] = '0; mp[a] = '0; mn[a] = '0; end
    node_top = NB;
  endtask

  task automatic insert(input int k, input int p);
    int b;
    b = bh(KW'(k));
    mk[node_top] = KW'(k); mp[node_top] = PW'(p); mn[node_top] = mn[b];
    mn[b] = AW'(node_top);
    node_top++;
  endtask

  // probe list and expectations
  logic [KW-1:0] pk [128];
  logic [PW-1:0] pp [128];
  int pn;
  logic [KW-1:0] ek [512];
  logic [PW-1:0] epp [512], ebp [512];
  bit eused [512];
  int en, got, exp_nodes, head_seen, node_seen;
  bit hold = 1'b0;

  task automatic add_probe(input int k);
    pk[pn] = KW'(k); pp[pn] = PW'(16'h8000 + pn); pn++;
  endtask

  task automatic build_expect();
    en = 0; exp_nodes = 0;
    for (int i = 0; i < pn; i++) begin
      int a;
      a = mn[bh(pk[i])];
      while (a != 0) begin
        exp_nodes++;
        if (mk[a] == pk[i]) begin
          ek[en] = pk[i]; epp[en] = pp[i]; ebp[en] = mp[a]; eused[en] = 1'b0; en++;
        end
        a = mn[a];
      end
    end
  endtask

  // memory model and result monitor
  logic [AW-1:0] qa [16];
  logic [TW-1:0] qt [16];
  int qn = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit r6_due = 1'b0;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rst_n) begin
      qn = 0; mem_rsp_valid = 1'b0; r6_due = 1'b0;
    end else begin
      if (r6_due) begin
        chk(in_ready == 1'b0, "R6 input stalled behind recirculated thread", in_ready, 0);
        r6_due = 1'b0;
      end
      mem_rsp_valid = 1'b0;
      if (!hold && qn > 0 && lfsr[0]) begin
        int i;
        logic [AW-1:0] a;
        i = int'(lfsr[7:1]) % qn;
        a = qa[i];
        mem_rsp_valid = 1'b1;
        mem_rsp_tag = qt[i];
        mem_rsp_data = {mk[a], mp[a], mn[a]};
        if (mn[a] != '0) r6_due = 1'b1;
        for (int j = i; j < qn - 1; j++) begin qa[j] = qa[j+1]; qt[j] = qt[j+1]; end
        qn--;
      end
      if (mem_req_valid) begin
        qa[qn] = mem_req_addr; qt[qn] = mem_req_tag; qn++;
        if (mem_req_addr < NB) begin
          if (head_seen < pn)
            chk(mem_req_addr == AW'(bh(pk[head_seen])), "R1 head address follows hash",
                mem_req_addr, bh(pk[head_seen]));
          head_seen++;
        end else node_seen++;
      end
      if (res_valid) begin
        bit found;
        found = 1'b0;
        for (int e = 0; e < en; e++) begin
          if (!found && !eused[e] && ek[e] == res_key && epp[e] == res_probe_pay
              && ebp[e] == res_build_pay) begin
            eused[e] = 1'b1; found = 1'b1;
          end
        end
        chk(found, "R4 result matches an expected joined record", res_key, -1);
        got++;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_eos = 1'b0; hold = 1'b0;
    got = 0; head_seen = 0; node_seen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic feed_all();
    for (int i = 0; i < pn; i++) begin
      in_valid = 1'b1; in_key = pk[i]; in_pay = pp[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic finish_run(input string name);
    int t;
    in_eos = 1'b1;
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done == 1'b1, {"R8 done raised: ", name}, done, 1);
    repeat (3) @(negedge clk);
    chk(got == en, {"R4 result count: ", name}, got, en);
    chk(head_seen == pn, {"R1 head reads: ", name}, head_seen, pn);
    chk(node_seen == exp_nodes, {"R5 R2 node reads follow chains: ", name}, node_seen, exp_nodes);
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // reset state R9
    pn = 0; en = 0; clear_table();
    do_reset();
    chk(in_ready == 1'b1, "R9 in_ready after reset", in_ready, 1);
    chk(mem_req_valid == 1'b0, "R9 mem_req_valid after reset", mem_req_valid, 0);
    chk(res_valid == 1'b0, "R9 res_valid after reset", res_valid, 0);
    chk(done == 1'b0, "R9 done after reset", done, 0);

    // T1: empty table, R3
    clear_table(); pn = 0;
    for (int k = 0; k < 16; k++) add_probe(k * 37 + 5);
    build_expect();
    do_reset();
    feed_all();
    finish_run("empty table");
    chk(got == 0, "R3 empty buckets produce no result", got, 0);
    chk(node_seen == 0, "R3 empty buckets produce no node read", node_seen, 0);

    // T2: unique keys, sweep with hits and misses
    clear_table(); pn = 0;
    for (int k = 0; k < 32; k++) insert(k, 16'h4000 + k);
    for (int k = 0; k < 64; k++) add_probe(k);
    build_expect();
    do_reset();
    feed_all();
    finish_run("unique keys");

    // T3: skewed chains with repeated keys
    clear_table(); pn = 0;
    for (int c = 0; c < 12; c++) insert(7, 16'h1000 + c);
    for (int c = 0; c < 5; c++) insert(23, 16'h2000 + c);
    for (int k = 100; k < 140; k++) insert(k, 16'h3000 + k);
    for (int c = 0; c < 3; c++) add_probe(7);
    for (int c = 0; c < 2; c++) add_probe(23);
    for (int k = 100; k < 120; k++) add_probe(k);
    for (int k = 500; k < 510; k++) add_probe(k);
    build_expect();
    do_reset();
    feed_all();
    finish_run("skewed chains");
    chk(en > 25, "R4 skew test has multiple matches per thread", en, 26);

    // T4: capacity with memory withheld, R7 and R8
    clear_table(); pn = 0;
    for (int k = 0; k < 20; k++) insert(k, 16'h5000 + k);
    for (int k = 0; k < 10; k++) add_probe(k * 2);
    build_expect();
    do_reset();
    hold = 1'b1;
    fork
      feed_all();
      begin
        repeat (30) @(negedge clk);
        chk(qn == NT, "R7 outstanding threads capped at NT", qn, NT);
        chk(in_ready == 1'b0, "R7 in_ready low with all tags busy", in_ready, 0);
        in_eos = 1'b1;
        repeat (2) @(negedge clk);
        chk(done == 1'b0, "R8 done low while threads outstanding", done, 0);
        in_eos = 1'b0;
        hold = 1'b0;
      end
    join
    finish_run("capacity");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule